// File: doc/BRIEF.md
# Element-Granular Chaining Scoreboard for a Vector Register File

This block tracks, for each architectural vector register, whether an in-flight instruction is still filling it and how many of its elements have been written so far. A consumer instruction asks on a read port for element `i` of register `r`. It is granted that element as soon as the producer has written it, so a dependent operation can start before its source vector is complete. Any active producer can be chained to at any time. The per-element progress check is the only gate; there is no fixed forwarding slot between producer and consumer.

Issue logic allocates a destination register before the producer starts. The functional unit pulses the write port once per element, in element order. Every read port compares its requested index against the selected register's progress counter in the same cycle. A register that is not being filled reads as fully valid. A second allocation to a register that is still being filled is refused, because two writers to one register are a structural hazard.

Top module: `chain_scoreboard`

## Requirements
- R1: After reset no register is marked filling, and a read of any element of any register is granted.
- R2: An allocation of a register that is not filling is accepted in the same cycle (`alloc_ok`=1). From the next cycle the register shows filling in `reg_busy` with zero elements written.
- R3: An allocation of a register that is already filling raises `alloc_hazard` and not `alloc_ok` in the same cycle. The register's filling state and written count stay as they were.
- R4: Each write-port pulse to a filling register raises that register's written count by one. A read of the element at the old count is therefore granted from the following cycle.
- R5: A read of a filling register is withheld when the requested index is not below the written count. This includes the element being written in that same cycle. A port with no request never shows a grant.
- R6: A read of a register that is not filling is granted whatever index is requested.
- R7: The write that brings the count to the vector length clears the register's filling flag in the next cycle. After that every element of the register reads as valid.
- R8: A write-port pulse aimed at a register that is not filling has no effect. A later allocation of that register still starts from zero written elements.
- R9: All read ports are evaluated independently in the same cycle. They may name the same register as each other and as the write port, with different element indices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Request to allocate a destination register to a new producer |
| alloc_reg | input | RW | Register number to allocate |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_hazard | output | 1 | Allocation refused: register already has an active writer |
| wr_vld | input | 1 | One element of the producer has been written |
| wr_reg | input | RW | Register receiving that element |
| rd_vld | input | NRD | Per-port element read request |
| rd_reg | input | NRD*RW | Per-port register number, port p in bits [p*RW +: RW] |
| rd_idx | input | NRD*IW | Per-port element index, port p in bits [p*IW +: IW] |
| rd_grant | output | NRD | Per-port grant: requested element is available |
| reg_busy | output | NREG | Per-register filling flag |

## Verification
If a written count is corrupted, it shows up on the first read that lands on the wrong side of the boundary. That is a grant one element too early or too late, in the same cycle the read is presented. A filling flag that is lost or stuck appears on `reg_busy` one cycle after the write or allocation that should have changed it. It also shows as a grant on an unwritten element, or as a refused allocation that should have succeeded. The reference model compares all grants, both allocation outputs and every filling flag each cycle, so a single wrong increment is seen no later than the next read near that register's boundary.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int CSB_NREG_DEFAULT = 8;
  localparam int CSB_VLEN_DEFAULT = 64;
  localparam int CSB_NRD_DEFAULT  = 2;

  typedef enum logic {
    LANE_VALID   = 1'b0,
    LANE_FILLING = 1'b1
  } lane_state_e;
endpackage

// File: rtl/csb_lane.sv
module csb_lane
  import csb_pkg::*;
#(
  parameter int VLEN = CSB_VLEN_DEFAULT,
  parameter int CW   = $clog2(VLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_hit,
  input  logic          wr_hit,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(VLEN - 1);

  lane_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (alloc_hit) begin
      st_d  = LANE_FILLING;
      cnt_d = '0;
    end else if (wr_hit) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) st_d = LANE_VALID;
    end
  end

  assign en = alloc_hit | wr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LANE_VALID;
      cnt_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q == LANE_FILLING);
  assign cnt  = cnt_q;
endmodule

// File: rtl/csb_rdport.sv
module csb_rdport #(
  parameter int NREG = 8,
  parameter int RW   = 3,
  parameter int IW   = 6,
  parameter int CW   = 7
) (
  input  logic              rd_vld,
  input  logic [RW-1:0]     rd_reg,
  input  logic [IW-1:0]     rd_idx,
  input  logic [NREG-1:0]   busy,
  input  logic [NREG*CW-1:0] cnt_flat,
  output logic              grant
);
  logic          sel_busy;
  logic [CW-1:0] sel_cnt;
  logic          elem_ready;

  always_comb begin
    sel_busy = busy[rd_reg];
    sel_cnt  = cnt_flat[rd_reg*CW +: CW];
    elem_ready = !sel_busy || (CW'(rd_idx) < sel_cnt);
    grant = rd_vld && elem_ready;
  end
endmodule

// File: rtl/chain_scoreboard.sv
module chain_scoreboard
  import csb_pkg::*;
#(
  parameter int  NREG = CSB_NREG_DEFAULT,
  parameter int  VLEN = CSB_VLEN_DEFAULT,
  parameter int  NRD  = CSB_NRD_DEFAULT,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(VLEN),
  localparam int CW   = $clog2(VLEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_vld,
  input  logic [RW-1:0]     alloc_reg,
  output logic              alloc_ok,
  output logic              alloc_hazard,
  input  logic              wr_vld,
  input  logic [RW-1:0]     wr_reg,
  input  logic [NRD-1:0]    rd_vld,
  input  logic [NRD*RW-1:0] rd_reg,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD-1:0]    rd_grant,
  output logic [NREG-1:0]   reg_busy
);
  logic [NREG-1:0]    busy_v;
  logic [NREG*CW-1:0] cnt_flat;
  logic [NREG-1:0]    alloc_hit;
  logic [NREG-1:0]    wr_hit;

  // Structural hazard: a register with an active writer cannot take another.
  always_comb begin
    alloc_hazard = alloc_vld &&  busy_v[alloc_reg];
    alloc_ok     = alloc_vld && !busy_v[alloc_reg];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_lane
    assign alloc_hit[g] = alloc_ok && (alloc_reg == RW'(g));
    assign wr_hit[g]    = wr_vld && (wr_reg == RW'(g)) && busy_v[g];

    csb_lane #(.VLEN(VLEN), .CW(CW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_hit (alloc_hit[g]),
      .wr_hit    (wr_hit[g]),
      .busy      (busy_v[g]),
      .cnt       (cnt_flat[g*CW +: CW])
    );
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    csb_rdport #(.NREG(NREG), .RW(RW), .IW(IW), .CW(CW)) u_rd (
      .rd_vld   (rd_vld[p]),
      .rd_reg   (rd_reg[p*RW +: RW]),
      .rd_idx   (rd_idx[p*IW +: IW]),
      .busy     (busy_v),
      .cnt_flat (cnt_flat),
      .grant    (rd_grant[p])
    );
  end

  assign reg_busy = busy_v;
endmodule

// File: rtl/csb_checker.sv
module csb_checker #(
  parameter int NREG = 8,
  parameter int NRD  = 2,
  parameter int RW   = 3,
  parameter int IW   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_vld,
  input logic [RW-1:0]     alloc_reg,
  input logic              alloc_ok,
  input logic              alloc_hazard,
  input logic              wr_vld,
  input logic [RW-1:0]     wr_reg,
  input logic [NRD-1:0]    rd_vld,
  input logic [NRD*RW-1:0] rd_reg,
  input logic [NRD*IW-1:0] rd_idx,
  input logic [NRD-1:0]    rd_grant,
  input logic [NREG-1:0]   reg_busy
);
  AST_ALLOC_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> reg_busy[$past(alloc_reg)]); // R2

  AST_HAZARD_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_hazard && !(wr_vld && wr_reg == alloc_reg)) |=> reg_busy[$past(alloc_reg)]); // R3

  AST_HAZARD_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |-> (alloc_ok != alloc_hazard)); // R3

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    AST_RISE_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_busy[g]) |-> $past(alloc_ok && alloc_reg == RW'(g))); // R2

    AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_busy[g]) |-> $past(wr_vld && wr_reg == RW'(g))); // R7
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld[p] && !reg_busy[rd_reg[p*RW +: RW]]) |-> rd_grant[p]); // R6

    AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld[p] |-> !rd_grant[p]); // R5

    AST_FRESH_ALLOC_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok |=> !(rd_grant[p] && rd_reg[p*RW +: RW] == $past(alloc_reg))); // R5
  end
endmodule

bind chain_scoreboard csb_checker #(
  .NREG(NREG), .NRD(NRD), .RW(RW), .IW(IW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_vld    (alloc_vld),
  .alloc_reg    (alloc_reg),
  .alloc_ok     (alloc_ok),
  .alloc_hazard (alloc_hazard),
  .wr_vld       (wr_vld),
  .wr_reg       (wr_reg),
  .rd_vld       (rd_vld),
  .rd_reg       (rd_reg),
  .rd_idx       (rd_idx),
  .rd_grant     (rd_grant),
  .reg_busy     (reg_busy)
);

// File: tb/chain_scoreboard_tb.sv
module chain_scoreboard_tb;
  localparam int NREG = 8;
  localparam int VLEN = 64;
  localparam int NRD  = 2;
  localparam int RW   = 3;
  localparam int IW   = 6;

  logic              clk;
  logic              rst_n;
  logic              alloc_vld;
  logic [RW-1:0]     alloc_reg;
  logic              alloc_ok;
  logic              alloc_hazard;
  logic              wr_vld;
  logic [RW-1:0]     wr_reg;
  logic [NRD-1:0]    rd_vld;
  logic [NRD*RW-1:0] rd_reg;
  logic [NRD*IW-1:0] rd_idx;
  logic [NRD-1:0]    rd_grant;
  logic [NREG-1:0]   reg_busy;

  chain_scoreboard #(.NREG(NREG), .VLEN(VLEN), .NRD(NRD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_reg(alloc_reg),
    .alloc_ok(alloc_ok), .alloc_hazard(alloc_hazard),
    .wr_vld(wr_vld), .wr_reg(wr_reg),
    .rd_vld(rd_vld), .rd_reg(rd_reg), .rd_idx(rd_idx),
    .rd_grant(rd_grant), .reg_busy(reg_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    busy_m [NREG];
  int    cnt_m  [NREG];
  int    checks;
  int    errors;
  string tag_ovr;
  bit    done;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string pick(string dflt);
    return (tag_ovr != "") ? tag_ovr : dflt;
  endfunction

  task automatic cycle(bit av, int ar, bit wv, int wr,
                       bit v0, int r0, int i0, bit v1, int r1, int i1);
    int  pv [NRD];
    int  pr [NRD];
    int  pi [NRD];
    bit  a_ok;
    pv[0] = v0; pr[0] = r0; pi[0] = i0;
    pv[1] = v1; pr[1] = r1; pi[1] = i1;
    alloc_vld = av;
    alloc_reg = RW'(ar);
    wr_vld    = wv;
    wr_reg    = RW'(wr);
    for (int p = 0; p < NRD; p++) begin
      rd_vld[p]          = pv[p][0];
      rd_reg[p*RW +: RW] = RW'(pr[p]);
      rd_idx[p*IW +: IW] = IW'(pi[p]);
    end
    #4;
    a_ok = av && (busy_m[ar] == 0);
    chk(pick(a_ok ? "R2" : "R3"), "alloc_ok", int'(alloc_ok), int'(a_ok));
    chk(pick("R3"), "alloc_hazard", int'(alloc_hazard), int'(av && busy_m[ar] != 0));
    for (int p = 0; p < NRD; p++) begin
      bit exp_g;
      string t;
      exp_g = pv[p][0] && (busy_m[pr[p]] == 0 || pi[p] < cnt_m[pr[p]]);
      if (!pv[p][0]) t = "R5";
      else if (busy_m[pr[p]] == 0) t = "R6";
      else t = exp_g ? "R4" : "R5";
      chk(pick(t), $sformatf("rd_grant[%0d]", p), int'(rd_grant[p]), int'(exp_g));
    end
    for (int r = 0; r < NREG; r++)
      chk(pick("R7"), $sformatf("reg_busy[%0d]", r), int'(reg_busy[r]), busy_m[r]);
    @(posedge clk);
    if (wv && busy_m[wr] != 0) begin
      cnt_m[wr]++;
      if (cnt_m[wr] == VLEN) busy_m[wr] = 0;
    end
    if (a_ok) begin
      busy_m[ar] = 1;
      cnt_m[ar]  = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0; tag_ovr = "";
    for (int r = 0; r < NREG; r++) begin busy_m[r] = 0; cnt_m[r] = 0; end
    rst_n = 1'b0; alloc_vld = 0; alloc_reg = '0; wr_vld = 0; wr_reg = '0;
    rd_vld = '0; rd_reg = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, any element of any register readable
    tag_ovr = "R1";
    cycle(0, 0, 0, 0, 1, 0, 63, 1, 7, 0);
    cycle(0, 0, 0, 0, 1, 3, 17, 1, 5, 40);
    tag_ovr = "";

    // R2 then R3: allocate reg 2, then a second writer is refused
    cycle(1, 2, 0, 0, 1, 2, 0, 0, 0, 0);
    cycle(1, 2, 0, 0, 1, 2, 0, 1, 2, 5);
    // R4 and R9: write reg 2 while both ports read it around the boundary
    for (int k = 0; k < 5; k++)
      cycle(0, 0, 1, 2, 1, 2, k, 1, 2, (k > 0) ? k - 1 : 0);
    cycle(1, 2, 1, 2, 1, 2, 5, 1, 2, 4);

    // R8: write to an idle register, then allocate it; it starts empty
    tag_ovr = "R8";
    cycle(0, 0, 1, 5, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 1, 5, 1, 5, 0, 0, 0, 0);
    cycle(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 1, 5, 0, 1, 5, 1);
    tag_ovr = "";

    // R7: finish reg 2 with reads chasing the written count
    while (busy_m[2] != 0)
      cycle(0, 0, 1, 2, 1, 2, cnt_m[2], 1, 2, cnt_m[2] - 1);
    cycle(0, 0, 0, 0, 1, 2, 63, 1, 2, 0);

    // R9: mixed traffic on several registers at once
    for (int n = 0; n < 6000; n++) begin
      int wrr;
      int r0;
      int r1;
      wrr = $urandom % NREG;
      r0  = $urandom % NREG;
      r1  = $urandom % NREG;
      cycle(($urandom % 8) == 0, $urandom % NREG,
            ($urandom % 4) != 0, wrr,
            ($urandom % 4) != 0, r0, (cnt_m[r0] + ($urandom % 5) + VLEN - 2) % VLEN,
            ($urandom % 4) != 0, r1, $urandom % VLEN);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule